// File: doc/BRIEF.md
# Card Reader Status Controller

This block controls a card reader and keeps its status. A read command carries a mode bit, an interrupt-inhibit bit, a base address and a column count. It is examined in the cycle it arrives. The block refuses it if:

- the reader is busy,
- the parameters are wrong, or
- one of the four feed interlocks is active.

Once a command is accepted, the block takes one card's worth of columns from an upstream 12-bit column stream. It writes each column to memory as a byte (translate mode) or as a halfword (image mode). It advances a write address and counts the columns down to zero.

Errors fall into two classes.

- **Immediate errors** mark the column data as unreliable. They are posted at once, end the transfer and request an interrupt.
- **Deferred errors** leave the current card's data valid. They are held back and reported only when the next read command is issued.

A test command clears a pending interrupt request and records that it did so. Three inputs clear status: a reader-level clear, a processor-level clear, and an off-line switch.

Top module: `card_rdr_ctrl`

## Requirements
- R1: After reset the status byte is 0x00, `irq`, `busy`, `wr_en`, `cmd_ack` and `cmd_rej` are 0, and `cols_left` is 0.
- R2: A read command (`cmd_valid`=1, `cmd_test`=0) that meets all of the following is accepted: the block is not busy, `cmd_count` equals NCOLS (80), `cmd_base` bit 0 is 0, and no interlock input is high. Acceptance pulses `cmd_ack` in the next cycle, raises `busy` and loads `cols_left` with 80.
- R3: A read command that passes the R2 parameter checks while any of `il_misfeed`, `il_not_ready`, `il_hopper_empty` or `il_stacker_full` is high is refused. `cmd_rej` pulses, status bit 1 is set and no transfer starts.
- R4: A read command whose count is not 80, or whose base address is odd, is refused with `cmd_rej` and leaves the status byte unchanged.
- R5: In translate mode (`cmd_image`=0), each column written gives `wr_wide`=0 and `wr_data`={8'h00, column[7:0]}. The address steps by 1.
- R6: In image mode (`cmd_image`=1), each column written gives `wr_wide`=1 and `wr_data`={4'h0, column}. The address steps by 2. At the end, `addr_now` is one past the last byte written.
- R7: `cols_left` drops by one for each column taken. The cycle after the column that brings it to zero, `busy` is 0 and `irq` is 1.
- R8: A command issued with `cmd_inhibit`=1 never raises `irq`, whether it ends normally or on an error.
- R9: A jam, photocell or parity error during a transfer sets status bit 0 in the next cycle, ends the transfer and raises `irq` unless inhibited. The same errors while idle are ignored, and so are columns while idle.
- R10: A deferred error (`err_late`) during a transfer leaves the status unchanged. It sets status bit 1 in the cycle after the next read command is issued.
- R11: A test command (`cmd_test`=1) pulses `cmd_ack`, clears `irq`, and sets status bit 5 only if `irq` was 1 at that moment.
- R12: While `offline_sw` is high, `busy` reads 1 and read commands are refused without any status change. A transfer already running still completes.
- R13: `rdr_clear` clears every status bit except one caused by a parity error. `cpu_clear` clears all of them. `offline_sw` clears a bit 1 caused by hopper-empty or stacker-full, but not one caused by misfeed or not-ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_clear | input | 1 | Processor-level clear of all status |
| rdr_clear | input | 1 | Reader-level clear (parity kept) |
| offline_sw | input | 1 | Off-line switch |
| cmd_valid | input | 1 | Command strobe |
| cmd_test | input | 1 | 1 = test command, 0 = read command |
| cmd_image | input | 1 | 0 = translate mode, 1 = image mode |
| cmd_inhibit | input | 1 | 1 = no interrupt for this command |
| cmd_base | input | AW | Start address, must be even |
| cmd_count | input | CNTW | Column count, must equal NCOLS |
| il_misfeed | input | 1 | Misfeed interlock |
| il_not_ready | input | 1 | Not-ready interlock |
| il_hopper_empty | input | 1 | Hopper-empty interlock |
| il_stacker_full | input | 1 | Stacker-full interlock |
| col_valid | input | 1 | Column strobe |
| col_code | input | CW | Column punch pattern |
| err_jam | input | 1 | Stacker jam (immediate) |
| err_parity | input | 1 | Control parity error (immediate) |
| err_photo | input | 1 | Photocell check (immediate) |
| err_late | input | 1 | Deferred-class error |
| cmd_ack | output | 1 | Command accepted pulse |
| cmd_rej | output | 1 | Command refused pulse |
| busy | output | 1 | Transfer running or off-line |
| wr_en | output | 1 | Memory write strobe |
| wr_wide | output | 1 | Write is a halfword |
| wr_addr | output | AW | Write address |
| wr_data | output | 16 | Write data |
| addr_now | output | AW | Current address register |
| cols_left | output | CNTW | Columns remaining |
| irq | output | 1 | Interrupt request |
| status | output | 8 | Status byte |

## Verification
The completion of the transfer and an immediate error can land on the same edge. The bench provokes this by presenting the 80th column together with a photocell error. It then expects, all in the following cycle:

- the column still written,
- status bit 0 set,
- `busy` low,
- a single `irq` level.

A second overlap is a test command arriving while `irq` is already set. There the bench checks that bit 5 records the clearing and that `irq` drops.

// File: rtl/crs_pkg.sv
package crs_pkg;
  localparam int ST_IMM  = 0;
  localparam int ST_UNIT = 1;
  localparam int ST_TCLR = 5;
  localparam int DW      = 16;
  localparam int NIL     = 4;
endpackage

// File: rtl/crs_cmd_gate.sv
module crs_cmd_gate #(
  parameter int NCOLS = 80,
  parameter int CNTW  = $clog2(NCOLS + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cmd_valid,
  input  logic                  cmd_test,
  input  logic                  base_lsb,
  input  logic [CNTW-1:0]       cmd_count,
  input  logic [crs_pkg::NIL-1:0] il,
  input  logic                  busy_in,
  output logic                  start,
  output logic                  read_issue,
  output logic                  is_test,
  output logic                  rej_mf,
  output logic                  rej_hs,
  output logic                  ack_q,
  output logic                  rej_q
);
  localparam logic [CNTW-1:0] FULL = CNTW'(NCOLS);

  logic rd, parm_ok, il_any;

  always_comb begin
    rd         = cmd_valid & ~cmd_test;
    read_issue = rd & ~busy_in;
    parm_ok    = (cmd_count == FULL) & ~base_lsb;
    il_any     = |il;
    start      = read_issue & parm_ok & ~il_any;
    rej_mf     = read_issue & parm_ok & (il[0] | il[1]);
    rej_hs     = read_issue & parm_ok & (il[2] | il[3]);
    is_test    = cmd_valid & cmd_test;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q <= 1'b0;
      rej_q <= 1'b0;
    end else begin
      ack_q <= start | is_test;
      rej_q <= rd & ~start;
    end
  end

  assert_ack_rej_apart_R2: assert property (@(posedge clk) disable iff (rst)
    ack_q |-> !rej_q);
endmodule

// File: rtl/crs_col_xfer.sv
module crs_col_xfer #(
  parameter int NCOLS = 80,
  parameter int AW    = 16,
  parameter int CW    = 12,
  parameter int CNTW  = $clog2(NCOLS + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic                   image_in,
  input  logic                   inh_in,
  input  logic [AW-1:0]          base_in,
  input  logic                   col_valid,
  input  logic [CW-1:0]          col_code,
  input  logic                   stop_err,
  output logic                   running,
  output logic                   h_q,
  output logic                   ev_done,
  output logic                   wr_en,
  output logic                   wr_wide,
  output logic [AW-1:0]          wr_addr,
  output logic [crs_pkg::DW-1:0] wr_data,
  output logic [AW-1:0]          addr_q,
  output logic [CNTW-1:0]        cnt_q
);
  localparam logic [CNTW-1:0] FULL = CNTW'(NCOLS);
  localparam logic [CNTW-1:0] ONE  = CNTW'(1);

  logic                   img_q, ev_col, stop;
  logic [AW-1:0]          step;
  logic [crs_pkg::DW-1:0] fmt;

  always_comb begin
    ev_col  = running & col_valid;
    ev_done = ev_col & (cnt_q == ONE);
    stop    = ev_done | (running & stop_err);
    step    = img_q ? AW'(2) : AW'(1);
    fmt     = img_q ? crs_pkg::DW'(col_code) : {8'h00, col_code[7:0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      img_q   <= 1'b0;
      h_q     <= 1'b0;
      addr_q  <= '0;
      cnt_q   <= '0;
      wr_en   <= 1'b0;
      wr_wide <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= ev_col;
      if (start) begin
        running <= 1'b1;
        img_q   <= image_in;
        h_q     <= inh_in;
        addr_q  <= base_in;
        cnt_q   <= FULL;
      end else if (running) begin
        if (ev_col) begin
          wr_addr <= addr_q;
          wr_data <= fmt;
          wr_wide <= img_q;
          addr_q  <= addr_q + step;
          cnt_q   <= cnt_q - ONE;
        end
        if (stop) running <= 1'b0;
      end
    end
  end

  assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= FULL);
  assert_wr_in_run_R9: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(running));
endmodule

// File: rtl/crs_status.sv
module crs_status (
  input  logic       clk,
  input  logic       rst,
  input  logic       cpu_clear,
  input  logic       rdr_clear,
  input  logic       offline_q,
  input  logic       is_test,
  input  logic       read_issue,
  input  logic       rej_mf,
  input  logic       rej_hs,
  input  logic       running,
  input  logic       h_q,
  input  logic       ev_done,
  input  logic       imm_hit,
  input  logic       par_hit,
  input  logic       late_hit,
  output logic [7:0] status,
  output logic       irq
);
  logic imm_q, par_q, mf_q, hs_q, def_pend, def_q, tclr_q, raise;

  always_comb begin
    raise  = ev_done | imm_hit | par_hit;
    status = '0;
    status[crs_pkg::ST_IMM]  = imm_q | par_q;
    status[crs_pkg::ST_UNIT] = mf_q | hs_q | def_q;
    status[crs_pkg::ST_TCLR] = tclr_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      {imm_q, par_q, mf_q, hs_q, def_pend, def_q, tclr_q, irq} <= '0;
    end else begin
      if (cpu_clear) begin
        {imm_q, par_q, mf_q, hs_q, def_pend, def_q, tclr_q, irq} <= '0;
      end else if (rdr_clear) begin
        {imm_q, mf_q, hs_q, def_pend, def_q, tclr_q} <= '0;
      end
      if (offline_q) hs_q <= 1'b0;
      if (is_test) begin
        irq <= 1'b0;
        if (irq) tclr_q <= 1'b1;
      end
      if (raise && !h_q) irq <= 1'b1;
      if (imm_hit)  imm_q <= 1'b1;
      if (par_hit)  par_q <= 1'b1;
      if (rej_mf)   mf_q  <= 1'b1;
      if (rej_hs)   hs_q  <= 1'b1;
      if (late_hit) def_pend <= 1'b1;
      if (read_issue && def_pend) begin
        def_q    <= 1'b1;
        def_pend <= 1'b0;
      end
    end
  end

  assert_irq_on_end_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(running) |-> (irq || h_q));
  assert_no_irq_inhibit_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> !h_q);
  assert_bit5_by_test_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(tclr_q) |-> $past(is_test && irq));
  assert_parity_sticky_R13: assert property (@(posedge clk) disable iff (rst)
    (par_q && !cpu_clear) |=> par_q);
endmodule

// File: rtl/card_rdr_ctrl.sv
module card_rdr_ctrl #(
  parameter int NCOLS = 80,
  parameter int AW    = 16,
  parameter int CW    = 12,
  parameter int CNTW  = $clog2(NCOLS + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cpu_clear,
  input  logic                   rdr_clear,
  input  logic                   offline_sw,
  input  logic                   cmd_valid,
  input  logic                   cmd_test,
  input  logic                   cmd_image,
  input  logic                   cmd_inhibit,
  input  logic [AW-1:0]          cmd_base,
  input  logic [CNTW-1:0]        cmd_count,
  input  logic                   il_misfeed,
  input  logic                   il_not_ready,
  input  logic                   il_hopper_empty,
  input  logic                   il_stacker_full,
  input  logic                   col_valid,
  input  logic [CW-1:0]          col_code,
  input  logic                   err_jam,
  input  logic                   err_parity,
  input  logic                   err_photo,
  input  logic                   err_late,
  output logic                   cmd_ack,
  output logic                   cmd_rej,
  output logic                   busy,
  output logic                   wr_en,
  output logic                   wr_wide,
  output logic [AW-1:0]          wr_addr,
  output logic [crs_pkg::DW-1:0] wr_data,
  output logic [AW-1:0]          addr_now,
  output logic [CNTW-1:0]        cols_left,
  output logic                   irq,
  output logic [7:0]             status
);
  logic offline_q, running, h_q, ev_done, start, read_issue, is_test;
  logic rej_mf, rej_hs, imm_hit, par_hit, late_hit;
  logic [crs_pkg::NIL-1:0] il;

  always_ff @(posedge clk) begin
    if (rst) offline_q <= 1'b0;
    else     offline_q <= offline_sw;
  end

  always_comb begin
    busy     = running | offline_q;
    il       = {il_stacker_full, il_hopper_empty, il_not_ready, il_misfeed};
    imm_hit  = running & (err_jam | err_photo);
    par_hit  = running & err_parity;
    late_hit = running & err_late;
  end

  crs_cmd_gate #(.NCOLS(NCOLS), .CNTW(CNTW)) u_gate (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_test(cmd_test),
    .base_lsb(cmd_base[0]), .cmd_count(cmd_count), .il(il), .busy_in(busy),
    .start(start), .read_issue(read_issue), .is_test(is_test),
    .rej_mf(rej_mf), .rej_hs(rej_hs), .ack_q(cmd_ack), .rej_q(cmd_rej)
  );

  crs_col_xfer #(.NCOLS(NCOLS), .AW(AW), .CW(CW), .CNTW(CNTW)) u_xfer (
    .clk(clk), .rst(rst), .start(start), .image_in(cmd_image),
    .inh_in(cmd_inhibit), .base_in(cmd_base), .col_valid(col_valid),
    .col_code(col_code), .stop_err(err_jam | err_photo | err_parity),
    .running(running), .h_q(h_q), .ev_done(ev_done), .wr_en(wr_en),
    .wr_wide(wr_wide), .wr_addr(wr_addr), .wr_data(wr_data),
    .addr_q(addr_now), .cnt_q(cols_left)
  );

  crs_status u_stat (
    .clk(clk), .rst(rst), .cpu_clear(cpu_clear), .rdr_clear(rdr_clear),
    .offline_q(offline_q), .is_test(is_test), .read_issue(read_issue),
    .rej_mf(rej_mf), .rej_hs(rej_hs), .running(running), .h_q(h_q),
    .ev_done(ev_done), .imm_hit(imm_hit), .par_hit(par_hit),
    .late_hit(late_hit), .status(status), .irq(irq)
  );

  assert_start_online_R12: assert property (@(posedge clk) disable iff (rst)
    $rose(running) |-> $past(!offline_q));
endmodule

// File: tb/card_rdr_ctrl_bench.sv
`timescale 1ns/1ps
module card_rdr_ctrl_bench;
  localparam int NCOLS = 80;
  localparam int AW = 16;
  localparam int CW = 12;
  localparam int CNTW = $clog2(NCOLS + 1);

  logic clk = 0, rst = 1, cpu_clear = 0, rdr_clear = 0, offline_sw = 0;
  logic cmd_valid = 0, cmd_test = 0, cmd_image = 0, cmd_inhibit = 0;
  logic [AW-1:0] cmd_base = 0;
  logic [CNTW-1:0] cmd_count = 0;
  logic il_misfeed = 0, il_not_ready = 0, il_hopper_empty = 0, il_stacker_full = 0;
  logic col_valid = 0;
  logic [CW-1:0] col_code = 0;
  logic err_jam = 0, err_parity = 0, err_photo = 0, err_late = 0;
  logic cmd_ack, cmd_rej, busy, wr_en, wr_wide, irq;
  logic [AW-1:0] wr_addr, addr_now;
  logic [15:0] wr_data;
  logic [CNTW-1:0] cols_left;
  logic [7:0] status;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  card_rdr_ctrl u_card_rdr_ctrl (.*);

  // Row layout: [31] image, [30] inhibit, [29] expect accept,
  // [28:25] interlocks {stacker,hopper,notready,misfeed}, [24:16] count, [15:0] base
  localparam logic [31:0] TBL [8] = '{
    {1'b0, 1'b0, 1'b1, 4'b0000, 9'd80, 16'h0100},
    {1'b1, 1'b0, 1'b1, 4'b0000, 9'd80, 16'h0200},
    {1'b0, 1'b1, 1'b1, 4'b0000, 9'd80, 16'h0300},
    {1'b1, 1'b1, 1'b1, 4'b0000, 9'd80, 16'h0400},
    {1'b0, 1'b0, 1'b0, 4'b0001, 9'd80, 16'h0500},
    {1'b1, 1'b0, 1'b0, 4'b1000, 9'd80, 16'h0600},
    {1'b0, 1'b0, 1'b0, 4'b0000, 9'd79, 16'h0700},
    {1'b0, 1'b0, 1'b0, 4'b0000, 9'd80, 16'h0701}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic test, input logic img, input logic inh,
                       input logic [AW-1:0] base, input logic [CNTW-1:0] cnt,
                       input logic [3:0] ilk);
    cmd_valid = 1; cmd_test = test; cmd_image = img; cmd_inhibit = inh;
    cmd_base = base; cmd_count = cnt;
    {il_stacker_full, il_hopper_empty, il_not_ready, il_misfeed} = ilk;
    @(negedge clk);
    cmd_valid = 0; cmd_test = 0;
    {il_stacker_full, il_hopper_empty, il_not_ready, il_misfeed} = 4'b0;
  endtask

  task automatic pulse_cpu_clear();
    cpu_clear = 1; @(negedge clk); cpu_clear = 0;
  endtask

  function automatic logic [CW-1:0] pat(input int i, input int k);
    return CW'(i * 37 + k * 5 + 1);
  endfunction

  function automatic logic [15:0] expd(input logic img, input logic [CW-1:0] c);
    return img ? {4'h0, c} : {8'h00, c[7:0]};
  endfunction

  // feed n columns, checking each write; returns with col_valid low
  task automatic feed(input int n, input int first, input int k, input logic img,
                      input logic [AW-1:0] base);
    for (int i = first; i < first + n; i++) begin
      col_valid = 1; col_code = pat(i, k);
      @(negedge clk);
      col_valid = 0;
      chk("R5/R6 wr_en", wr_en, 1);
      chk("R5 R6 wr_addr", wr_addr, base + AW'(img ? 2 * i : i));
      chk("R5 R6 wr_data", wr_data, expd(img, pat(i, k)));
      chk("R5 R6 wr_wide", wr_wide, img);
      chk("R7 cols_left", cols_left, NCOLS - i - 1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 status", status, 8'h00);
    chk("R1 irq", irq, 0);
    chk("R1 busy", busy, 0);
    chk("R1 wr_en", wr_en, 0);
    chk("R1 ack/rej", {cmd_ack, cmd_rej}, 0);
    chk("R1 cols_left", cols_left, 0);

    for (int r = 0; r < 8; r++) begin
      logic img, inh, acc;
      logic [3:0] ilk;
      logic [AW-1:0] base;
      img = TBL[r][31]; inh = TBL[r][30]; acc = TBL[r][29];
      ilk = TBL[r][28:25]; base = TBL[r][15:0];
      issue(0, img, inh, base, CNTW'(TBL[r][24:16]), ilk);
      chk("R2 R3 R4 ack", cmd_ack, acc);
      chk("R2 R3 R4 rej", cmd_rej, !acc);
      chk("R2 R3 busy", busy, acc);
      chk("R3 R4 status", status, (ilk != 0) ? 8'h02 : 8'h00);
      if (acc) begin
        chk("R2 cols_left", cols_left, NCOLS);
        feed(NCOLS, 0, r, img, base);
        chk("R7 busy end", busy, 0);
        chk("R7 R8 irq", irq, !inh);
        chk("R6 final addr", addr_now, base + AW'(img ? 2 * NCOLS : NCOLS));
      end
      pulse_cpu_clear();
    end

    // R9 immediate error mid-transfer, then idle columns ignored
    issue(0, 0, 0, 16'h1000, NCOLS, 0);
    feed(10, 0, 9, 0, 16'h1000);
    err_jam = 1; @(negedge clk); err_jam = 0;
    chk("R9 bit0", status, 8'h01);
    chk("R9 busy", busy, 0);
    chk("R9 irq", irq, 1);
    col_valid = 1; err_photo = 1; @(negedge clk); col_valid = 0; err_photo = 0;
    chk("R9 idle column ignored", wr_en, 0);
    chk("R9 idle count kept", cols_left, NCOLS - 10);
    // R11 test command while irq pending
    issue(1, 0, 0, 0, 0, 0);
    chk("R11 ack", cmd_ack, 1);
    chk("R11 irq cleared", irq, 0);
    chk("R11 bit5", status, 8'h21);
    rdr_clear = 1; @(negedge clk); rdr_clear = 0;
    chk("R13 reader clear", status, 8'h00);
    issue(1, 0, 0, 0, 0, 0);
    chk("R11 no bit5 without irq", status, 8'h00);

    // Collision: last column with photocell error, inhibited variant checks R8
    issue(0, 1, 0, 16'h2000, NCOLS, 0);
    feed(NCOLS - 1, 0, 3, 1, 16'h2000);
    col_valid = 1; col_code = 12'hABC; err_photo = 1;
    @(negedge clk); col_valid = 0; err_photo = 0;
    chk("R9 collision write", wr_en, 1);
    chk("R6 collision data", wr_data, 16'h0ABC);
    chk("R9 collision bit0", status, 8'h01);
    chk("R7 collision busy", busy, 0);
    chk("R7 collision irq", irq, 1);
    pulse_cpu_clear();
    issue(0, 0, 1, 16'h2100, NCOLS, 0);
    feed(3, 0, 4, 0, 16'h2100);
    err_jam = 1; @(negedge clk); err_jam = 0;
    chk("R8 inhibited error irq", irq, 0);
    chk("R8 inhibited error bit0", status, 8'h01);
    pulse_cpu_clear();

    // R10 deferred error
    issue(0, 0, 0, 16'h3000, NCOLS, 0);
    feed(5, 0, 6, 0, 16'h3000);
    err_late = 1; @(negedge clk); err_late = 0;
    chk("R10 no early status", status, 8'h00);
    feed(NCOLS - 5, 5, 6, 0, 16'h3000);
    chk("R10 status after op", status, 8'h00);
    issue(0, 0, 0, 16'h3200, NCOLS, 0);
    chk("R10 ack next", cmd_ack, 1);
    chk("R10 published", status, 8'h02);
    feed(NCOLS, 0, 7, 0, 16'h3200);
    pulse_cpu_clear();

    // R13 parity survives reader clear
    issue(0, 0, 0, 16'h4000, NCOLS, 0);
    err_parity = 1; @(negedge clk); err_parity = 0;
    chk("R9 parity bit0", status, 8'h01);
    rdr_clear = 1; @(negedge clk); rdr_clear = 0;
    chk("R13 parity kept", status, 8'h01);
    pulse_cpu_clear();
    chk("R13 cpu clear", status, 8'h00);

    // R12 offline during transfer
    issue(0, 1, 0, 16'h5000, NCOLS, 0);
    feed(5, 0, 8, 1, 16'h5000);
    offline_sw = 1; @(negedge clk);
    chk("R12 busy offline", busy, 1);
    feed(NCOLS - 5, 5, 8, 1, 16'h5000);
    chk("R12 op completes irq", irq, 1);
    chk("R12 op completes count", cols_left, 0);
    chk("R12 still busy", busy, 1);
    pulse_cpu_clear();
    issue(0, 0, 0, 16'h5200, NCOLS, 0);
    chk("R12 rejected offline", cmd_rej, 1);
    chk("R12 no status", status, 8'h00);
    offline_sw = 0; @(negedge clk); @(negedge clk);
    chk("R12 busy released", busy, 0);

    // R13 offline clears hopper/stacker cause only
    issue(0, 0, 0, 16'h6000, NCOLS, 4'b0100);
    chk("R3 hopper bit1", status, 8'h02);
    offline_sw = 1; @(negedge clk); @(negedge clk); offline_sw = 0;
    @(negedge clk); @(negedge clk);
    chk("R13 offline clears hopper", status, 8'h00);
    issue(0, 0, 0, 16'h6000, NCOLS, 4'b0001);
    chk("R3 misfeed bit1", status, 8'h02);
    offline_sw = 1; @(negedge clk); @(negedge clk); offline_sw = 0;
    @(negedge clk); @(negedge clk);
    chk("R13 offline keeps misfeed", status, 8'h02);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule